// File: doc/BRIEF.md
# Windowed Region Access Guard

This block sits on the request path of a bus master in front of a 96 KB internal RAM window. The window spans byte addresses 0x3FFE_8000 to 0x3FFF_FFFF and is cut into twelve regions of 8 KB each. Every request is classified by address. A request that lands inside the window is looked up in a per-region permission bit. It is then either forwarded downstream or dropped with an error pulse. A request outside the window is forwarded without any check.

The permission bits live in two 32-bit table registers. Regions 0 to 2 use bits 29, 30 and 31 of table 0. Regions 3 to 11 use bits 0 to 8 of table 1, in ascending region order. A write port updates one table at a time. Only a caller whose process identifier is 0 or 1 may change a table. Writes from identifiers 2 to 7 are discarded and flagged. The lookup is registered, so each verdict appears one clock after the request.

Top module: `region_guard`

## Requirements
- R1: After reset both table registers read back as 0xFFFF_FFFF. Every region grants access until a table is written.
- R2: A request with address A, where 0x3FFE_8000 <= A <= 0x3FFF_FFFF, selects region k = (A - 0x3FFE_8000) >> 13, for k from 0 to 11.
- R3: For k from 0 to 2 the permission bit is table 0 bit (29 + k). For k from 3 to 11 it is table 1 bit (k - 3). A bit value of 1 grants the access and 0 denies it.
- R4: A granted request (req_valid high at clock edge N) gives fwd_valid high for exactly one cycle after edge N+1... more precisely, fwd_valid is high in the cycle following edge N, with fwd_addr and fwd_write equal to the request's address and write flag.
- R5: A denied request gives deny_err high for one cycle after edge N. fwd_valid stays low for that request.
- R6: A request whose address is outside the window is forwarded on every table setting.
- R7: A table write (cfg_we high, cfg_sel = 0 for table 0 and 1 for table 1) from proc_id 0 or 1 loads all 32 bits of cfg_wdata. It takes effect for requests at later clock edges. cfg_viol stays low.
- R8: A table write from proc_id 2 to 7 leaves both tables unchanged and pulses cfg_viol high for one cycle after the edge.
- R9: cfg_rdata shows the table chosen by cfg_sel, combinationally from the stored value.
- R10: With no request, fwd_valid and deny_err are low; they are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | 32 | Request byte address |
| req_write | input | 1 | Request is a write |
| proc_id | input | 3 | Process identifier of the current caller |
| cfg_we | input | 1 | Table write strobe |
| cfg_sel | input | 1 | Table select for write and readback |
| cfg_wdata | input | 32 | Table write data |
| cfg_rdata | output | 32 | Selected table contents |
| cfg_viol | output | 1 | One-cycle pulse: table write refused |
| fwd_valid | output | 1 | Forwarded request valid |
| fwd_addr | output | 32 | Forwarded request address |
| fwd_write | output | 1 | Forwarded request write flag |
| deny_err | output | 1 | One-cycle pulse: request blocked |

## Verification
The checker watches some properties on every cycle. Each request yields exactly one verdict one cycle later. Verdicts never overlap, and idle cycles stay quiet. Addresses outside the window are always forwarded with their address intact. Refused writes always raise cfg_viol, and unprivileged writes never change cfg_rdata. Other behaviours can only be shown by the bench's scenarios. These are the region split at the 8 KB boundaries, the bit positions in both tables, the all-ones reset contents, and the effect of a privileged write on later grants. The bench sweeps all 4096 twelve-bit permission masks and probes every region under each mask.

// File: rtl/rgn_pkg.sv
package rgn_pkg;
  localparam int unsigned ADDR_W = 32;
  localparam int unsigned TBL_W  = 32;
  localparam int unsigned PID_W  = 3;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [TBL_W-1:0]  tbl_t;

  typedef struct packed {
    logic  fwd;
    logic  deny;
    logic  write;
    addr_t addr;
  } verdict_t;
endpackage

// File: rtl/rgn_decode.sv
module rgn_decode
  import rgn_pkg::*;
#(
  parameter logic [31:0] WIN_BASE = 32'h3FFE_8000,
  parameter int unsigned SHIFT    = 13,
  parameter int unsigned NREG     = 12,
  localparam int unsigned IDX_W   = $clog2(NREG)
) (
  input  addr_t            addr,
  output logic             in_win,
  output logic [IDX_W-1:0] idx
);
  addr_t offset;
  addr_t slot;

  always_comb begin
    offset = addr - WIN_BASE;
    slot   = offset >> SHIFT;
    in_win = (addr >= WIN_BASE) && (slot < NREG);
    idx    = slot[IDX_W-1:0];
  end
endmodule

// File: rtl/rgn_perm_regs.sv
module rgn_perm_regs
  import rgn_pkg::*;
#(
  parameter int unsigned NREG     = 12,
  parameter int unsigned T0_LSB   = 29,
  parameter int unsigned T0_CNT   = 3,
  parameter int unsigned PRIV_MAX = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic             sel,
  input  tbl_t             wdata,
  input  logic [PID_W-1:0] pid,
  output tbl_t             rdata,
  output logic             viol,
  output logic [NREG-1:0]  perm
);
  tbl_t tbl0_q, tbl1_q;
  logic priv;

  assign priv = (pid <= PID_W'(PRIV_MAX));

  always_ff @(posedge clk) begin
    if (rst) begin
      tbl0_q <= '1;
      tbl1_q <= '1;
      viol   <= 1'b0;
    end else begin
      viol <= we && !priv;
      if (we && priv) begin
        if (sel) tbl1_q <= wdata;
        else     tbl0_q <= wdata;
      end
    end
  end

  assign rdata = sel ? tbl1_q : tbl0_q;

  for (genvar i = 0; i < NREG; i++) begin : g_map
    if (i < T0_CNT) begin : g_t0
      assign perm[i] = tbl0_q[T0_LSB + i];
    end else begin : g_t1
      assign perm[i] = tbl1_q[i - T0_CNT];
    end
  end
endmodule

// File: rtl/region_guard.sv
module region_guard
  import rgn_pkg::*;
#(
  parameter logic [31:0] WIN_BASE = 32'h3FFE_8000,
  parameter int unsigned SHIFT    = 13,
  parameter int unsigned NREG     = 12,
  parameter int unsigned T0_LSB   = 29,
  parameter int unsigned T0_CNT   = 3,
  parameter int unsigned PRIV_MAX = 1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        req_valid,
  input  logic [31:0] req_addr,
  input  logic        req_write,
  input  logic [2:0]  proc_id,
  input  logic        cfg_we,
  input  logic        cfg_sel,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  output logic        cfg_viol,
  output logic        fwd_valid,
  output logic [31:0] fwd_addr,
  output logic        fwd_write,
  output logic        deny_err
);
  localparam int unsigned IDX_W = $clog2(NREG);

  logic             in_win;
  logic [IDX_W-1:0] idx;
  logic [NREG-1:0]  perm;
  logic             allow;
  verdict_t         vd_d, vd_q;

  rgn_decode #(.WIN_BASE(WIN_BASE), .SHIFT(SHIFT), .NREG(NREG)) u_dec (
    .addr(req_addr), .in_win(in_win), .idx(idx)
  );

  rgn_perm_regs #(.NREG(NREG), .T0_LSB(T0_LSB), .T0_CNT(T0_CNT),
                  .PRIV_MAX(PRIV_MAX)) u_regs (
    .clk(clk), .rst(rst), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
    .pid(proc_id), .rdata(cfg_rdata), .viol(cfg_viol), .perm(perm)
  );

  always_comb begin
    allow      = !in_win || perm[idx];
    vd_d.fwd   = req_valid && allow;
    vd_d.deny  = req_valid && !allow;
    vd_d.write = req_write;
    vd_d.addr  = req_addr;
  end

  always_ff @(posedge clk) begin
    if (rst) vd_q <= '0;
    else     vd_q <= vd_d;
  end

  assign fwd_valid = vd_q.fwd;
  assign deny_err  = vd_q.deny;
  assign fwd_addr  = vd_q.addr;
  assign fwd_write = vd_q.write;
endmodule

// File: rtl/region_guard_chk.sv
module region_guard_chk (
  input logic        clk,
  input logic        rst,
  input logic        req_valid,
  input logic [31:0] req_addr,
  input logic        req_write,
  input logic [2:0]  proc_id,
  input logic        cfg_we,
  input logic        cfg_sel,
  input logic [31:0] cfg_rdata,
  input logic        cfg_viol,
  input logic        fwd_valid,
  input logic [31:0] fwd_addr,
  input logic        fwd_write,
  input logic        deny_err
);
  // R10
  one_verdict_chk: assert property (@(posedge clk) disable iff (rst)
    !(fwd_valid && deny_err));

  // R4 R5
  verdict_follows_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> (fwd_valid || deny_err));

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (!fwd_valid && !deny_err));

  // R4
  fwd_payload_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> (fwd_valid -> (fwd_addr == $past(req_addr)
                                 && fwd_write == $past(req_write))));

  // R6
  outside_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && (req_addr < 32'h3FFE_8000 || req_addr > 32'h3FFF_FFFF))
      |=> fwd_valid);

  // R8
  refused_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && proc_id > 3'd1) |=> cfg_viol);

  // R7
  priv_no_flag_chk: assert property (@(posedge clk) disable iff (rst)
    !(cfg_we && proc_id > 3'd1) |=> !cfg_viol);

  // R8
  refused_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && proc_id > 3'd1) |=> (cfg_sel != $past(cfg_sel)
                                     || cfg_rdata == $past(cfg_rdata)));
endmodule

bind region_guard region_guard_chk u_chk (.*);

// File: tb/sim_region_guard.sv
module sim_region_guard;
  localparam logic [31:0] BASE = 32'h3FFE_8000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic [2:0]  proc_id = '0;
  logic        cfg_we = 1'b0;
  logic        cfg_sel = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        cfg_viol, fwd_valid, fwd_write, deny_err;
  logic [31:0] fwd_addr;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  region_guard u0 (.*);

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic access(logic [31:0] a, logic w, bit grant, string req);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_write = w;
    @(negedge clk);
    req_valid = 1'b0;
    chk(fwd_valid == grant && deny_err == !grant, req, "verdict",
        {30'd0, fwd_valid, deny_err}, {30'd0, grant, !grant});
    if (grant)
      chk(fwd_addr == a && fwd_write == w, req, "payload", fwd_addr, a);
  endtask

  task automatic wr(logic sel, logic [31:0] d, logic [2:0] pid, string req);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d; proc_id = pid;
    @(negedge clk);
    cfg_we = 1'b0;
    chk(cfg_viol == (pid > 3'd1), req, "cfg_viol",
        {31'd0, cfg_viol}, {31'd0, pid > 3'd1});
  endtask

  task automatic rb(logic sel, logic [31:0] exp, string req);
    cfg_sel = sel;
    #1;
    chk(cfg_rdata == exp, req, sel ? "table1" : "table0", cfg_rdata, exp);
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 R10 reset state
    chk(!fwd_valid && !deny_err && !cfg_viol, "R10", "idle after reset",
        {29'd0, fwd_valid, deny_err, cfg_viol}, 32'd0);
    @(negedge clk);
    rb(1'b0, 32'hFFFF_FFFF, "R1");
    rb(1'b1, 32'hFFFF_FFFF, "R1");
    for (int k = 0; k < 12; k++) begin
      access(BASE + 32'(k) * 32'h2000, 1'b0, 1'b1, "R1");
      access(BASE + 32'(k) * 32'h2000 + 32'h1FFF, 1'b1, 1'b1, "R1");
    end

    // R8 unprivileged writes refused
    for (int p = 2; p < 8; p++) begin
      wr(1'b0, 32'h0, 3'(p), "R8");
      wr(1'b1, 32'h0, 3'(p), "R8");
      rb(1'b0, 32'hFFFF_FFFF, "R8");
      rb(1'b1, 32'hFFFF_FFFF, "R8");
    end
    access(BASE, 1'b0, 1'b1, "R8");
    access(32'h3FFF_FFFC, 1'b0, 1'b1, "R8");

    // R7 both privileged ids, R9 readback
    wr(1'b0, 32'h1234_5678, 3'd0, "R7");
    wr(1'b1, 32'h9ABC_DEF0, 3'd1, "R7");
    rb(1'b0, 32'h1234_5678, "R9");
    rb(1'b1, 32'h9ABC_DEF0, "R9");

    // R6 outside the window with every region denied
    wr(1'b0, 32'h0, 3'd1, "R7");
    wr(1'b1, 32'h0, 3'd0, "R7");
    access(32'h3FFE_7FFF, 1'b1, 1'b1, "R6");
    access(32'h0000_0000, 1'b0, 1'b1, "R6");
    access(32'h4000_0000, 1'b1, 1'b1, "R6");
    access(32'hFFFF_FFFF, 1'b0, 1'b1, "R6");
    access(BASE, 1'b0, 1'b0, "R5");
    access(32'h3FFF_FFFF, 1'b1, 1'b0, "R5");

    // R2 R3 R4 R5 exhaustive mask sweep
    for (int c = 0; c < 4096; c++) begin
      logic [11:0] m;
      m = 12'(c);
      wr(1'b0, {m[2:0], 29'(c * 3)}, 3'(c & 1), "R7");
      wr(1'b1, {23'(c), m[11:3]}, 3'(c & 1), "R7");
      for (int k = 0; k < 12; k++) begin
        access(BASE + 32'(k) * 32'h2000 + 32'((c * 37 + k * 101) % 8192),
               1'(k & 1), m[k], m[k] ? "R3 R4 R2" : "R3 R5 R2");
      end
    end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule